// File: doc/BRIEF.md
# Programmable Wide-Frame UART

This block is an asynchronous serial transmitter and receiver for a peripheral subsystem. A 16-bit divisor sets the bit rate, and each bit lasts 16 oversampling ticks. The word length can be set from 7 to 12 data bits. Even or odd parity can be added, and the frame ends with one or two stop bits. The receiver reports parity, framing and overrun errors through sticky flags, which software clears by writing ones to them. Each direction has its own masked interrupt, which is a single-cycle pulse.

Software uses a four-word register port. Word 0 is the divisor. Word 1 is the control word. Word 2 is the data window: a write fills the single-entry transmit holding register, and a read returns the received word and frees the receive holding register. Word 3 is status. The serial pins are `txd` and `rxd`. Both idle high.

Top module: `wfuart`

## Requirements
- R1: One bit period is 16*(DIV+1) clock cycles, where DIV is the 16-bit value in register word 0. This covers 16 to 1,048,576 clocks per bit. A transmitted start bit lasts exactly one bit period.
- R2: A frame is a low start bit, then N data bits sent least significant bit first. N = 7 + ctrl[2:0] for codes 0..5; codes 6 and 7 select 12 bits.
- R3: ctrl[4:3] selects parity: 1 = even, 2 = odd, 0 or 3 = none. When parity is enabled, one parity bit follows the data bits. It makes the number of ones across data and parity even (even mode) or odd (odd mode).
- R4: The frame ends with one high stop bit, or two when ctrl[5] is 1. `txd` is high whenever no frame is being sent.
- R5: The receiver accepts a start bit only if the line is still low at the start bit's midpoint. It then samples each later bit at its middle. A low pulse shorter than half a bit is ignored, and rx_full (status bit 0) stays 0.
- R6: A received parity bit that does not match the configured parity sets status bit 2 (parity error). The flag stays set across later good frames.
- R7: A low level where the first stop bit should be sets status bit 3 (framing error).
- R8: If a word completes while status bit 0 (rx_full) is still set, status bit 4 (overrun) is set. The new word replaces the old one.
- R9: Writing word 3 clears each of status bits 2..4 that is written as 1. Bits written as 0 keep their value.
- R10: `irq_tx` pulses high for one cycle at the end of each transmitted frame when ctrl[6] is 1. `irq_rx` pulses high for one cycle for each received word when ctrl[7] is 1. A cleared enable bit suppresses its pulse.
- R11: Status bit 1 is 1 when the transmit holding register is empty. A write to word 2 fills it, and the transmitter empties it when it takes the word. Reading word 2 returns the received word, zero-extended, and clears rx_full. After reset the status reads 0x0002.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effect on word 2 only) |
| addr | input | 2 | Register word select |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the selected word |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| irq_tx | output | 1 | Transmit-done interrupt pulse |
| irq_rx | output | 1 | Receive-done interrupt pulse |

## Verification
The bench measures the length of the start bit at a divisor above zero. A transmitter that loaded a word between ticks, or that counted the divisor off by one, would produce a start bit of the wrong length. It sends frames at the 7-bit and 12-bit limits with both parity senses and two stop bits. A wrong length decode or a wrong parity sense would shift or corrupt the captured bits. On the receive side it sends:
- a short glitch, which a receiver without midpoint validation would take as a word;
- a bad-parity frame followed by a good one, which a non-sticky flag would lose;
- a frame with a low stop bit;
- two unread words.

It then clears the flags with selective write-one-to-clear patterns. A design that cleared all flags on any write would fail these checks.

// File: rtl/wfuart_pkg.sv
package wfuart_pkg;
    localparam int DATA_W = 12;

    localparam logic [1:0] PAR_EVEN = 2'd1;
    localparam logic [1:0] PAR_ODD  = 2'd2;

    typedef enum logic [2:0] {ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP} ser_st_e;

    function automatic logic [3:0] data_len(input logic [2:0] code);
        return (code > 3'd5) ? 4'd12 : 4'(code) + 4'd7;
    endfunction

    function automatic logic has_par(input logic [1:0] mode);
        return (mode == PAR_EVEN) || (mode == PAR_ODD);
    endfunction

    function automatic logic par_bit(input logic [DATA_W-1:0] d, input logic [3:0] n,
                                     input logic [1:0] mode);
        logic x;
        x = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < int'(n)) x ^= d[i];
        end
        return (mode == PAR_ODD) ? ~x : x;
    endfunction
endpackage

// File: rtl/wfuart_tick.sv
module wfuart_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    typedef struct packed { logic [DIV_W-1:0] cnt; } tick_st_t;
    tick_st_t d, q;

    assign tick = (q.cnt >= div);

    always_comb begin
        d = q;
        d.cnt = tick ? '0 : q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R1
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div != '0) |=> (!tick || div == '0));
endmodule

// File: rtl/wfuart_tx.sv
module wfuart_tx
    import wfuart_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [2:0]        len_code,
    input  logic [1:0]        par_mode,
    input  logic              stop2,
    input  logic              load_req,
    input  logic [DATA_W-1:0] load_data,
    output logic              load_ack,
    output logic              txd,
    output logic              done
);
    typedef struct packed {
        ser_st_e           st;
        logic [3:0]        sub;
        logic [3:0]        idx;
        logic [DATA_W-1:0] sh;
        logic [3:0]        len;
        logic [1:0]        par;
        logic              stop2;
        logic              pbit;
        logic              txd;
        logic              done;
        logic              ack;
    } tx_st_t;
    tx_st_t d, q;

    assign txd      = q.txd;
    assign done     = q.done;
    assign load_ack = d.ack;

    always_comb begin
        d = q;
        d.done = 1'b0;
        d.ack  = 1'b0;
        if (q.st == ST_IDLE) begin
            d.txd = 1'b1;
            if (tick && load_req) begin
                d.st    = ST_START;
                d.sub   = '0;
                d.sh    = load_data;
                d.len   = data_len(len_code);
                d.par   = par_mode;
                d.stop2 = stop2;
                d.pbit  = par_bit(load_data, data_len(len_code), par_mode);
                d.txd   = 1'b0;
                d.ack   = 1'b1;
            end
        end else if (tick) begin
            d.sub = q.sub + 1'b1;
            if (q.sub == 4'd15) begin
                unique case (q.st)
                    ST_START: begin
                        d.st  = ST_DATA;
                        d.idx = '0;
                        d.txd = q.sh[0];
                        d.sh  = q.sh >> 1;
                    end
                    ST_DATA: begin
                        if (q.idx == q.len - 4'd1) begin
                            d.st  = has_par(q.par) ? ST_PAR : ST_STOP;
                            d.txd = has_par(q.par) ? q.pbit : 1'b1;
                            d.idx = '0;
                        end else begin
                            d.idx = q.idx + 1'b1;
                            d.txd = q.sh[0];
                            d.sh  = q.sh >> 1;
                        end
                    end
                    ST_PAR: begin
                        d.st  = ST_STOP;
                        d.idx = '0;
                        d.txd = 1'b1;
                    end
                    default: begin
                        d.txd = 1'b1;
                        if (q.stop2 && q.idx == '0) d.idx = 4'd1;
                        else begin
                            d.st   = ST_IDLE;
                            d.done = 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.st  <= ST_IDLE;
            q.txd <= 1'b1;
        end else begin
            q <= d;
        end
    end

    // R4
    txd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && q.st != ST_IDLE) |=> $stable(txd));
    // R4
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && !load_ack) |=> txd);
endmodule

// File: rtl/wfuart_rx.sv
module wfuart_rx
    import wfuart_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [2:0]        len_code,
    input  logic [1:0]        par_mode,
    input  logic              rxd,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              perr,
    output logic              ferr
);
    typedef struct packed {
        logic              s1;
        logic              s2;
        ser_st_e           st;
        logic [3:0]        sub;
        logic [3:0]        idx;
        logic [3:0]        len;
        logic [1:0]        par;
        logic [DATA_W-1:0] data;
        logic              perr;
        logic              ferr;
        logic              done;
    } rx_st_t;
    rx_st_t d, q;

    assign done = q.done;
    assign data = q.data;
    assign perr = q.perr;
    assign ferr = q.ferr;

    always_comb begin
        d = q;
        d.s1   = rxd;
        d.s2   = q.s1;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (!q.s2) begin
                    d.st  = ST_START;
                    d.sub = '0;
                    d.len = data_len(len_code);
                    d.par = par_mode;
                end
            end
            ST_START: begin
                if (tick) begin
                    d.sub = q.sub + 1'b1;
                    if (q.sub == 4'd7) begin
                        if (q.s2) d.st = ST_IDLE;
                        else begin
                            d.st   = ST_DATA;
                            d.sub  = '0;
                            d.idx  = '0;
                            d.data = '0;
                            d.perr = 1'b0;
                            d.ferr = 1'b0;
                        end
                    end
                end
            end
            ST_DATA: begin
                if (tick) begin
                    d.sub = q.sub + 1'b1;
                    if (q.sub == 4'd15) begin
                        d.data[q.idx] = q.s2;
                        if (q.idx == q.len - 4'd1)
                            d.st = has_par(q.par) ? ST_PAR : ST_STOP;
                        else
                            d.idx = q.idx + 1'b1;
                    end
                end
            end
            ST_PAR: begin
                if (tick) begin
                    d.sub = q.sub + 1'b1;
                    if (q.sub == 4'd15) begin
                        d.perr = (q.s2 != par_bit(q.data, q.len, q.par));
                        d.st   = ST_STOP;
                    end
                end
            end
            default: begin
                if (tick) begin
                    d.sub = q.sub + 1'b1;
                    if (q.sub == 4'd15) begin
                        d.ferr = !q.s2;
                        d.done = 1'b1;
                        d.st   = ST_IDLE;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.s1 <= 1'b1;
            q.s2 <= 1'b1;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    // R5
    rx_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7
    rx_stop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ferr) |-> $past(!q.s2));
endmodule

// File: rtl/wfuart.sv
module wfuart
    import wfuart_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [1:0]  addr,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    output logic        txd,
    input  logic        rxd,
    output logic        irq_tx,
    output logic        irq_rx
);
    localparam logic [1:0] A_DIV = 2'd0, A_CTRL = 2'd1, A_DATA = 2'd2, A_STAT = 2'd3;

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [7:0]        ctrl;
        logic [DATA_W-1:0] hold;
        logic              hold_full;
        logic [DATA_W-1:0] rx_data;
        logic              rx_full;
        logic              perr;
        logic              ferr;
        logic              ovr;
        logic              irq_tx;
        logic              irq_rx;
    } regs_t;
    regs_t d, q;

    logic              tick, tx_ack, tx_done, rx_done, rx_perr, rx_ferr;
    logic [DATA_W-1:0] rx_word;

    wfuart_tick #(.DIV_W(DIV_W)) i_tick (
        .clk(clk), .rst_n(rst_n), .div(q.div), .tick(tick));

    wfuart_tx i_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .len_code(q.ctrl[2:0]),
        .par_mode(q.ctrl[4:3]), .stop2(q.ctrl[5]), .load_req(q.hold_full),
        .load_data(q.hold), .load_ack(tx_ack), .txd(txd), .done(tx_done));

    wfuart_rx i_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .len_code(q.ctrl[2:0]),
        .par_mode(q.ctrl[4:3]), .rxd(rxd), .done(rx_done), .data(rx_word),
        .perr(rx_perr), .ferr(rx_ferr));

    assign irq_tx = q.irq_tx;
    assign irq_rx = q.irq_rx;

    always_comb begin
        unique case (addr)
            A_DIV:   rdata = 16'(q.div);
            A_CTRL:  rdata = {8'd0, q.ctrl};
            A_DATA:  rdata = 16'(q.rx_data);
            default: rdata = {11'd0, q.ovr, q.ferr, q.perr, !q.hold_full, q.rx_full};
        endcase
    end

    always_comb begin
        d = q;
        d.irq_tx = tx_done && q.ctrl[6];
        d.irq_rx = rx_done && q.ctrl[7];
        if (tx_ack) d.hold_full = 1'b0;
        if (rd_en && addr == A_DATA) d.rx_full = 1'b0;
        if (wr_en) begin
            unique case (addr)
                A_DIV:  d.div  = wdata[DIV_W-1:0];
                A_CTRL: d.ctrl = wdata[7:0];
                A_DATA: begin
                    d.hold      = wdata[DATA_W-1:0];
                    d.hold_full = 1'b1;
                end
                default: begin
                    if (wdata[2]) d.perr = 1'b0;
                    if (wdata[3]) d.ferr = 1'b0;
                    if (wdata[4]) d.ovr  = 1'b0;
                end
            endcase
        end
        if (rx_done) begin
            if (q.rx_full && !(rd_en && addr == A_DATA)) d.ovr = 1'b1;
            d.rx_data = rx_word;
            d.rx_full = 1'b1;
            if (rx_perr) d.perr = 1'b1;
            if (rx_ferr) d.ferr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R10
    irq_tx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx |=> !irq_tx);
    // R10
    irq_rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx |=> !irq_rx);
    // R8
    ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.ovr) |-> $past(q.rx_full));
    // R9
    w1c_perr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_STAT && wdata[2] && !rx_done) |=> !q.perr);
    // R11
    hold_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ack |-> q.hold_full);
endmodule

// File: tb/test_wfuart.sv
module test_wfuart;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        txd, irq_tx, irq_rx;
    logic        rxd = 1'b1;
    int checks = 0, errors = 0, ntx = 0, nrx = 0;
    int bitclk = 16;

    always #2 clk = ~clk;

    wfuart i_wfuart (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .txd(txd), .rxd(rxd), .irq_tx(irq_tx), .irq_rx(irq_rx));

    always @(negedge clk) begin
        if (irq_tx) ntx++;
        if (irq_rx) nrx++;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] v);
        @(negedge clk); addr = a; wdata = v; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        @(negedge clk); addr = a; rd_en = 1'b1; #1 v = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    function automatic logic ref_par(input logic [11:0] v, input int n, input int mode);
        logic x = 1'b0;
        for (int i = 0; i < n; i++) x ^= v[i];
        return (mode == 2) ? ~x : x;
    endfunction

    task automatic setup(input int div, input int code, input int par, input bit s2,
                         input bit ten, input bit ren);
        bitclk = 16 * (div + 1);
        wr(2'd0, 16'(div));
        wr(2'd1, 16'({ren, ten, s2, 2'(par), 3'(code)}));
    endtask

    task automatic capture(input int n, input int par, input bit s2, input logic [11:0] exp,
                           input string tag);
        logic [11:0] got = '0;
        int guard = 0;
        while (txd !== 1'b0 && guard < 20000) begin @(negedge clk); guard++; end
        repeat (bitclk / 2) @(negedge clk);
        check(txd == 1'b0, {tag, " R2 start"}, txd, 0);
        for (int i = 0; i < n; i++) begin
            repeat (bitclk) @(negedge clk);
            got[i] = txd;
        end
        check(got == exp, {tag, " R2 data"}, got, exp);
        if (par == 1 || par == 2) begin
            repeat (bitclk) @(negedge clk);
            check(txd == ref_par(exp, n, par), {tag, " R3 parity"}, txd, ref_par(exp, n, par));
        end
        repeat (bitclk) @(negedge clk);
        check(txd == 1'b1, {tag, " R4 stop1"}, txd, 1);
        if (s2) begin
            repeat (bitclk) @(negedge clk);
            check(txd == 1'b1, {tag, " R4 stop2"}, txd, 1);
        end
    endtask

    task automatic send(input int n, input logic [11:0] v, input int par, input bit bad_par,
                        input bit stop_hi);
        @(negedge clk); rxd = 1'b0; repeat (bitclk) @(negedge clk);
        for (int i = 0; i < n; i++) begin rxd = v[i]; repeat (bitclk) @(negedge clk); end
        if (par == 1 || par == 2) begin
            rxd = ref_par(v, n, par) ^ bad_par; repeat (bitclk) @(negedge clk);
        end
        rxd = stop_hi; repeat (bitclk) @(negedge clk);
        rxd = 1'b1; repeat (bitclk * 2) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [15:0] v;
        rd(2'd3, v);
        check(v == 16'h0002, "R11 reset status", v, 2);
        check(txd == 1'b1 && irq_tx == 1'b0 && irq_rx == 1'b0, "R4 reset idle", txd, 1);
    endtask

    task automatic t_tx_basic;
        int n0;
        setup(0, 1, 0, 0, 1, 0);
        n0 = ntx;
        wr(2'd2, 16'h0A5);
        capture(8, 0, 0, 12'h0A5, "basic8");
        repeat (20) @(negedge clk);
        check(ntx - n0 == 1, "R10 irq_tx one pulse", ntx - n0, 1);
    endtask

    task automatic t_tx_wide;
        setup(0, 5, 2, 1, 0, 0);
        wr(2'd2, 16'hB3C);
        capture(12, 2, 1, 12'hB3C, "wide12 odd");
        setup(0, 7, 1, 0, 0, 0);
        wr(2'd2, 16'h5A1);
        capture(12, 1, 0, 12'h5A1, "code7 even");
    endtask

    task automatic t_tx_narrow;
        setup(0, 0, 1, 0, 0, 0);
        wr(2'd2, 16'hFDB);
        capture(7, 1, 0, 12'h05B, "narrow7 even");
    endtask

    task automatic t_baud;
        int len = 0;
        setup(2, 1, 0, 0, 0, 0);
        wr(2'd2, 16'h001);
        while (txd !== 1'b0) @(negedge clk);
        while (txd === 1'b0 && len < 1000) begin len++; @(negedge clk); end
        check(len == 48, "R1 start bit length", len, 48);
        repeat (8 * 48 + 100) @(negedge clk);
    endtask

    task automatic t_hold;
        logic [15:0] v;
        setup(2, 1, 0, 0, 0, 0);
        wr(2'd2, 16'h033);
        wr(2'd2, 16'h0C4);
        rd(2'd3, v);
        check(v[1] == 1'b0, "R11 hold full while busy", v[1], 0);
        capture(8, 0, 0, 12'h033, "hold first");
        capture(8, 0, 0, 12'h0C4, "hold second");
        rd(2'd3, v);
        check(v[1] == 1'b1, "R11 hold empty after", v[1], 1);
    endtask

    task automatic t_tx_mask;
        int n0;
        setup(0, 1, 0, 0, 0, 0);
        n0 = ntx;
        wr(2'd2, 16'h012);
        capture(8, 0, 0, 12'h012, "masked");
        repeat (20) @(negedge clk);
        check(ntx == n0, "R10 irq_tx masked", ntx - n0, 0);
    endtask

    task automatic t_rx_basic;
        logic [15:0] v;
        int n0;
        setup(0, 1, 0, 0, 0, 1);
        n0 = nrx;
        send(8, 12'h03C, 0, 0, 1);
        rd(2'd3, v);
        check(v[0] == 1'b1, "R2 rx_full set", v[0], 1);
        rd(2'd2, v);
        check(v == 16'h003C, "R2 rx data", v, 16'h3C);
        rd(2'd3, v);
        check(v[0] == 1'b0 && v[4:2] == 3'b0, "R11 rx_full cleared", v, 2);
        check(nrx - n0 == 1, "R10 irq_rx one pulse", nrx - n0, 1);
    endtask

    task automatic t_rx_parity;
        logic [15:0] v;
        setup(0, 5, 1, 0, 0, 0);
        send(12, 12'hA53, 1, 0, 1);
        rd(2'd2, v);
        check(v == 16'h0A53, "R6 good parity data", v, 16'hA53);
        rd(2'd3, v);
        check(v[2] == 1'b0, "R6 no perr on good", v[2], 0);
        send(12, 12'h3C7, 1, 1, 1);
        rd(2'd2, v);
        send(12, 12'h111, 1, 0, 1);
        rd(2'd2, v);
        rd(2'd3, v);
        check(v[2] == 1'b1, "R6 perr sticky", v[2], 1);
        wr(2'd3, 16'h0010);
        rd(2'd3, v);
        check(v[2] == 1'b1, "R9 write 0 keeps perr", v[2], 1);
        wr(2'd3, 16'h0004);
        rd(2'd3, v);
        check(v[2] == 1'b0, "R9 w1c perr", v[2], 0);
    endtask

    task automatic t_framing;
        logic [15:0] v;
        setup(0, 1, 0, 0, 0, 0);
        send(8, 12'h081, 0, 0, 0);
        rd(2'd2, v);
        rd(2'd3, v);
        check(v[3] == 1'b1 && v[0] == 1'b0, "R7 framing error", v, 8);
        wr(2'd3, 16'h0008);
        rd(2'd3, v);
        check(v[3] == 1'b0, "R9 w1c ferr", v[3], 0);
    endtask

    task automatic t_overrun;
        logic [15:0] v;
        setup(0, 1, 2, 0, 0, 0);
        send(8, 12'h011, 2, 0, 1);
        send(8, 12'h0EE, 2, 0, 1);
        rd(2'd3, v);
        check(v[4] == 1'b1, "R8 overrun set", v[4], 1);
        rd(2'd2, v);
        check(v == 16'h00EE, "R8 newest word kept", v, 16'hEE);
        wr(2'd3, 16'h001C);
        rd(2'd3, v);
        check(v[4:2] == 3'b0, "R9 w1c all", v[4:2], 0);
    endtask

    task automatic t_glitch;
        logic [15:0] v;
        setup(0, 1, 0, 0, 0, 0);
        @(negedge clk); rxd = 1'b0;
        repeat (4) @(negedge clk);
        rxd = 1'b1;
        repeat (bitclk * 14) @(negedge clk);
        rd(2'd3, v);
        check(v[0] == 1'b0, "R5 glitch rejected", v[0], 0);
        send(8, 12'h069, 0, 0, 1);
        rd(2'd2, v);
        check(v == 16'h0069, "R5 rx after glitch", v, 16'h69);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_tx_basic();
        t_tx_wide();
        t_tx_narrow();
        t_baud();
        t_hold();
        t_tx_mask();
        t_rx_basic();
        t_rx_parity();
        t_framing();
        t_overrun();
        t_glitch();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule